// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

The router gathers level-type device interrupt requests into one shared request vector, one bit per source. Sources are identified by a source number. A device agent posts a request by presenting the source number with a post strobe, and it withdraws the request by presenting the number with a clear strobe. Each of the CPUs owns a full-width mask register. For each CPU the router keeps a masked-request register that always holds the mask ANDed with the shared vector. A per-CPU interrupt line shows whether any masked bit is set.

Software uses a simple 64-bit register port with valid, write, address, size and data inputs. The register index is the byte address shifted right by six, so every register occupies a 64-byte stride. Masks can be read and written. The masked-request registers and the shared vector are read-only. Any access that is not a full 64-bit access, and any write to a register that cannot be written, leaves the state unchanged and raises a sticky error flag.

Top module: `irq_mask_router`

## Requirements
- R1: After reset every mask, the request vector, every masked-request register, all interrupt outputs and the error flag are zero.
- R2: A post of source n sets bit n of the request vector at the next clock edge. The vector reads back at register index 2*NCPU (index 8 by default).
- R3: A clear of source n whose bit is set clears that bit, and every CPU's masked-request value follows at the same edge.
- R4: A clear of source n whose bit is already zero changes nothing.
- R5: Each CPU k's masked-request register, which reads at index NCPU+k, always equals mask k AND the request vector.
- R6: A legal write to index k (k < NCPU) replaces mask k entirely. A newly set mask bit over a pending request raises cpu_irq[k], and a removed bit stops contributing to it.
- R7: cpu_irq[k] equals the OR of CPU k's masked-request register, one clock cycle after that register changes.
- R8: The register index is reg_addr shifted right by 6, and the low six address bits are ignored. Mask k is at index k. Reads of unmapped indices return zero.
- R9: Only reg_size code 2'b11 (64-bit) is legal. Any other size sets err_flag, changes no state and, on a read, returns zero data.
- R10: A legal-size write to an index of NCPU or above sets err_flag and changes no state. err_flag stays set until reset.
- R11: A read returns, on the cycle after it is presented, the register value from before that clock edge, with reg_rvld high for that one cycle.
- R12: A post and a clear of the same source in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_post_vld | input | 1 | Post strobe for a device source |
| src_post_id | input | 6 | Number of the source being posted |
| src_clr_vld | input | 1 | Clear strobe for a device source |
| src_clr_id | input | 6 | Number of the source being cleared |
| reg_vld | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address; index is addr >> 6 |
| reg_size | input | 2 | Access size code; 2'b11 = 64-bit |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid while reg_rvld is high |
| reg_rvld | output | 1 | Read response strobe |
| err_flag | output | 1 | Sticky access error |
| cpu_irq | output | 4 | Per-CPU device interrupt line |

## Verification
The bench targets a mask write that lands in the same cycle as a post or clear. A design that computed the masked value from stale operands would show a masked register that disagrees with mask AND request. A spurious clear is also driven. If the design toggled the bit instead of ignoring the clear, a phantom request would appear. A post and a clear of the same source in one cycle are issued together, and a wrong ordering would drop the request. Illegal sizes and read-only writes are checked for both the sticky flag and for untouched state, which catches a decoder that still lets the write through. Nonzero low address bits are used to expose a decoder that uses the wrong shift.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int DATA_W = 64;
  localparam int STRIDE_SHIFT = 6;

  typedef logic [1:0] acc_size_t;
  localparam acc_size_t SIZE_DWORD = 2'b11;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_kind_t;

endpackage

// File: rtl/irq_src_vector.sv
module irq_src_vector #(
  parameter int NSRC = 64,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            post_vld,
  input  logic [SW-1:0]   post_id,
  input  logic            clr_vld,
  input  logic [SW-1:0]   clr_id,
  output logic [NSRC-1:0] req_nxt,
  output logic [NSRC-1:0] req_q
);

  logic req_en;

  always_comb begin
    req_nxt = req_q;
    if (clr_vld && req_q[clr_id]) begin
      req_nxt[clr_id] = 1'b0;
    end
    if (post_vld) begin
      req_nxt[post_id] = 1'b1;
    end
  end

  assign req_en = post_vld | clr_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (req_en) begin
      req_q <= req_nxt;
    end
  end

  // R2
  post_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_vld |=> req_q[$past(post_id)]);

  // R4
  spurious_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !req_q[clr_id] && !post_vld) |=> $stable(req_q));

  // R3
  clr_drops_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !post_vld) |=> !req_q[$past(clr_id)]);

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic [NSRC-1:0] req_nxt,
  input  logic [NSRC-1:0] req_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] masked_q,
  output logic            irq_q
);

  logic [NSRC-1:0] mask_nxt;
  logic [NSRC-1:0] masked_nxt;
  logic            irq_nxt;

  always_comb begin
    mask_nxt   = mask_we ? mask_wdata : mask_q;
    masked_nxt = mask_nxt & req_nxt;
    irq_nxt    = |masked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      masked_q <= masked_nxt;
      irq_q    <= irq_nxt;
    end
  end

  // R5
  masked_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q == (mask_q & req_q));

  // R7
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(|masked_q)));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_router_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 4,
  parameter int AW   = 12,
  localparam int IW  = AW - STRIDE_SHIFT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_vld,
  input  logic                      reg_wr,
  input  logic [IW-1:0]             reg_idx,
  input  acc_size_t                 reg_size,
  input  logic [NCPU-1:0][NSRC-1:0] mask_q,
  input  logic [NCPU-1:0][NSRC-1:0] masked_q,
  input  logic [NSRC-1:0]           req_q,
  output logic [NCPU-1:0]           mask_we,
  output logic [DATA_W-1:0]         rdata_q,
  output logic                      rvld_q,
  output logic                      err_q
);

  localparam int IDX_REQ = 2 * NCPU;

  acc_kind_t         kind;
  logic              size_ok;
  logic              idx_mask;
  logic              bad_wr;
  logic              bad_size;
  logic              err_nxt;
  logic              rvld_nxt;
  logic [NSRC-1:0]   rd_sel;
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    if (!reg_vld)     kind = ACC_IDLE;
    else if (reg_wr)  kind = ACC_WRITE;
    else              kind = ACC_READ;
  end

  assign size_ok  = (reg_size == SIZE_DWORD);
  assign idx_mask = (reg_idx < IW'(NCPU));
  assign bad_size = (kind != ACC_IDLE) && !size_ok;
  assign bad_wr   = (kind == ACC_WRITE) && size_ok && !idx_mask;

  for (genvar k = 0; k < NCPU; k++) begin : g_we
    assign mask_we[k] = (kind == ACC_WRITE) && size_ok && (reg_idx == IW'(k));
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NCPU; k++) begin
      if (reg_idx == IW'(k))        rd_sel = mask_q[k];
      if (reg_idx == IW'(NCPU + k)) rd_sel = masked_q[k];
    end
    if (reg_idx == IW'(IDX_REQ))    rd_sel = req_q;
    rdata_nxt = size_ok ? DATA_W'(rd_sel) : '0;
    rvld_nxt  = (kind == ACC_READ);
    err_nxt   = err_q | bad_size | bad_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rvld_nxt) begin
      rdata_q <= rdata_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rvld_q <= rvld_nxt;
      err_q  <= err_nxt;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && reg_size != SIZE_DWORD) |=> err_q);

  // R9
  bad_size_nowe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && reg_size != SIZE_DWORD) |-> (mask_we == '0));

  // R10
  one_mask_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we));

  // R11
  rvld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && !reg_wr) |=> rvld_q);

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 4,
  parameter int AW   = 12,
  localparam int SW  = $clog2(NSRC),
  localparam int IW  = AW - STRIDE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_post_vld,
  input  logic [SW-1:0]     src_post_id,
  input  logic              src_clr_vld,
  input  logic [SW-1:0]     src_clr_id,
  input  logic              reg_vld,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvld,
  output logic              err_flag,
  output logic [NCPU-1:0]   cpu_irq
);

  logic [NSRC-1:0]           req_nxt;
  logic [NSRC-1:0]           req_q;
  logic [NCPU-1:0][NSRC-1:0] mask_q;
  logic [NCPU-1:0][NSRC-1:0] masked_q;
  logic [NCPU-1:0]           mask_we;
  logic [IW-1:0]             reg_idx;
  logic                      addr_lo_unused;

  assign reg_idx        = reg_addr[AW-1:STRIDE_SHIFT];
  assign addr_lo_unused = ^reg_addr[STRIDE_SHIFT-1:0];

  irq_src_vector #(.NSRC(NSRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_vld (src_post_vld),
    .post_id  (src_post_id),
    .clr_vld  (src_clr_vld),
    .clr_id   (src_clr_id),
    .req_nxt  (req_nxt),
    .req_q    (req_q)
  );

  for (genvar k = 0; k < NCPU; k++) begin : g_lane
    irq_cpu_lane #(.NSRC(NSRC)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (mask_we[k]),
      .mask_wdata (reg_wdata[NSRC-1:0]),
      .req_nxt    (req_nxt),
      .req_q      (req_q),
      .mask_q     (mask_q[k]),
      .masked_q   (masked_q[k]),
      .irq_q      (cpu_irq[k])
    );
  end

  irq_reg_port #(.NSRC(NSRC), .NCPU(NCPU), .AW(AW)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_vld  (reg_vld),
    .reg_wr   (reg_wr),
    .reg_idx  (reg_idx),
    .reg_size (reg_size),
    .mask_q   (mask_q),
    .masked_q (masked_q),
    .req_q    (req_q),
    .mask_we  (mask_we),
    .rdata_q  (reg_rdata),
    .rvld_q   (reg_rvld),
    .err_q    (err_flag)
  );

  // R12
  post_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_post_vld && src_clr_vld && src_post_id == src_clr_id) |=> req_q[$past(src_post_id)]);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (cpu_irq == '0 && !err_flag));

endmodule

// File: tb/sim_irq_mask_router.sv
module sim_irq_mask_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_post_vld = 1'b0;
  logic [5:0]  src_post_id = '0;
  logic        src_clr_vld = 1'b0;
  logic [5:0]  src_clr_id = '0;
  logic        reg_vld = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [1:0]  reg_size = 2'b11;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_rvld;
  logic        err_flag;
  logic [3:0]  cpu_irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] m_mask [4];
  logic [63:0] m_req;
  logic        m_err;

  always #4 clk = ~clk;

  irq_mask_router u0 (
    .clk(clk), .rst_n(rst_n),
    .src_post_vld(src_post_vld), .src_post_id(src_post_id),
    .src_clr_vld(src_clr_vld), .src_clr_id(src_clr_id),
    .reg_vld(reg_vld), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvld(reg_rvld),
    .err_flag(err_flag), .cpu_irq(cpu_irq)
  );

  function automatic logic [63:0] exp_read(int idx, logic [1:0] sz);
    if (sz != 2'b11) return 64'd0;
    if (idx < 4) return m_mask[idx];
    if (idx < 8) return m_mask[idx-4] & m_req;
    if (idx == 8) return m_req;
    return 64'd0;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = |(m_mask[k] & m_req);
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    src_post_vld = 0; src_clr_vld = 0; reg_vld = 0; reg_wr = 0;
    reg_size = 2'b11; reg_wdata = '0; reg_addr = '0;
  endtask

  // one cycle with whatever inputs are driven; inputs already set after negedge
  task automatic cycle(string req);
    logic [63:0] rd;
    logic [3:0]  irq_e;
    bit          is_rd;
    int          idx;
    logic        sz_ok;
    idx   = int'(reg_addr[11:6]);
    sz_ok = (reg_size == 2'b11);
    is_rd = reg_vld && !reg_wr;
    rd    = exp_read(idx, reg_size);
    irq_e = exp_irq();
    @(posedge clk);
    if (reg_vld && reg_wr && sz_ok && idx < 4) m_mask[idx] = reg_wdata;
    if (reg_vld && (!sz_ok || (reg_wr && idx >= 4))) m_err = 1'b1;
    if (src_clr_vld && m_req[src_clr_id]) m_req[src_clr_id] = 1'b0;
    if (src_post_vld) m_req[src_post_id] = 1'b1;
    @(negedge clk);
    check({req, " R7 irq"}, 64'(cpu_irq), 64'(irq_e));
    check({req, " R10 err"}, 64'(err_flag), 64'(m_err));
    check({req, " R11 rvld"}, 64'(reg_rvld), 64'(is_rd));
    if (is_rd) check({req, " R11 rdata"}, reg_rdata, rd);
    idle_in();
  endtask

  task automatic rd_reg(string req, int idx, logic [5:0] lo);
    reg_vld = 1; reg_wr = 0; reg_addr = {idx[5:0], lo};
    cycle(req);
  endtask

  task automatic wr_reg(string req, int idx, logic [63:0] d, logic [1:0] sz);
    reg_vld = 1; reg_wr = 1; reg_addr = {idx[5:0], 6'd0}; reg_wdata = d; reg_size = sz;
    cycle(req);
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) m_mask[k] = '0;
    m_req = '0; m_err = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1: reset state
    check("R1 irq", 64'(cpu_irq), 64'd0);
    check("R1 err", 64'(err_flag), 64'd0);
    for (int i = 0; i < 10; i++) rd_reg("R1 read", i, 6'd0);

    // R2 post, R6 rising mask bit, R8 low bits ignored
    src_post_vld = 1; src_post_id = 6'd5; cycle("R2 post5");
    rd_reg("R2 req", 8, 6'h2a);
    wr_reg("R6 mask0 set", 0, 64'h20, 2'b11);
    cycle("R6 irq rise");
    check("R6 irq0", 64'(cpu_irq[0]), 64'd1);
    rd_reg("R5 masked0", 4, 6'h3f);
    rd_reg("R8 mask0", 0, 6'h11);
    rd_reg("R8 unmapped", 12, 6'h00);

    // R4 spurious clear
    src_clr_vld = 1; src_clr_id = 6'd9; cycle("R4 spurious");
    rd_reg("R4 req", 8, 6'd0);
    check("R4 req value", reg_rdata, 64'h20);

    // R3 clear drops request, irq falls one cycle later
    src_clr_vld = 1; src_clr_id = 6'd5; cycle("R3 clear5");
    cycle("R3 irq fall");
    check("R3 irq0", 64'(cpu_irq[0]), 64'd0);

    // R12 post and clear same source
    src_post_vld = 1; src_post_id = 6'd63; src_clr_vld = 1; src_clr_id = 6'd63;
    cycle("R12 both");
    rd_reg("R12 req", 8, 6'd0);
    check("R12 bit63", reg_rdata, 64'h8000_0000_0000_0000);

    // R6 mask write plus post same cycle, then removal
    wr_reg("R6 mask3", 3, 64'h8000_0000_0000_0001, 2'b11);
    src_post_vld = 1; src_post_id = 6'd0; reg_vld = 1; reg_wr = 1;
    reg_addr = {6'd2, 6'd0}; reg_wdata = 64'h1; cycle("R5 same cycle");
    rd_reg("R5 masked2", 6, 6'd0);
    wr_reg("R6 mask3 clr", 3, 64'h0, 2'b11);
    cycle("R6 removed");
    check("R6 irq3", 64'(cpu_irq[3]), 64'd0);

    // R9 illegal size
    wr_reg("R9 bad size wr", 1, 64'hffff, 2'b10);
    check("R9 err", 64'(err_flag), 64'd1);
    rd_reg("R9 mask1 kept", 1, 6'd0);
    reg_vld = 1; reg_wr = 0; reg_addr = {6'd8, 6'd0}; reg_size = 2'b01;
    cycle("R9 bad size rd");

    // R10 read-only write
    do_reset();
    src_post_vld = 1; src_post_id = 6'd7; cycle("R10 setup");
    wr_reg("R10 ro wr", 8, 64'h0, 2'b11);
    wr_reg("R10 ro wr masked", 5, 64'hff, 2'b11);
    rd_reg("R10 req kept", 8, 6'd0);
    check("R10 req value", reg_rdata, 64'h80);
    check("R10 sticky", 64'(err_flag), 64'd1);

    // random phase
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(99));
      src_post_vld = ($urandom_range(2) == 0);
      src_post_id  = 6'($urandom_range(63));
      src_clr_vld  = ($urandom_range(2) == 0);
      src_clr_id   = ($urandom_range(3) == 0) ? src_post_id : 6'($urandom_range(63));
      if (r < 30) begin
        reg_vld = 1; reg_wr = 1;
        reg_addr = {6'($urandom_range(3)), 6'($urandom_range(63))};
        reg_wdata = {$urandom, $urandom};
        reg_size = 2'b11;
      end else if (r < 75) begin
        reg_vld = 1; reg_wr = 0;
        reg_addr = {6'($urandom_range(10)), 6'($urandom_range(63))};
        reg_size = ($urandom_range(19) == 0) ? 2'b10 : 2'b11;
      end else if (r < 77 && n > 3000) begin
        reg_vld = 1; reg_wr = 1;
        reg_addr = {6'($urandom_range(4, 9)), 6'd0};
        reg_size = 2'b11;
      end
      cycle("R5 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule